// File: doc/BRIEF.md
# Memory-Mapped Output Address Decoder

This block sits between a processor's single load/store port and the things that port can reach: a small data RAM and two output device registers. The processor presents an address, a write strobe and write data. The block compares the word part of the address against two fixed device locations. That comparison decides which single write enable a store raises: the RAM's, device one's or device two's. The same comparison also produces a two-bit source code, and that code chooses what the processor sees on its read data bus.

Each device register is a plain enabled flop bank. It keeps the last value stored to its address and drives that value outward to the device side. Any address that matches neither device location goes to the RAM. The RAM is modelled as a simple word array with a synchronous write and a combinational read. Address decode and read selection are purely combinational, so a load returns its data in the same cycle it is presented. A store takes effect at the next rising clock edge.

Top module: `mmio_bridge`

## Requirements
- R1: When `memWrite` is high and address bits [31:2] equal those of 0xFFFFFFF4 (byte offset bits [1:0] ignored), `dev1Out` takes `writeData` at the next rising edge.
- R2: When `memWrite` is high and address bits [31:2] equal those of 0xFFFFFFF8, `dev2Out` takes `writeData` at the next rising edge.
- R3: A store to any other address writes RAM word `addr[7:2]` (default depth 64 words), and a later load from an address with the same word index returns that value.
- R4: A store to either device address leaves the RAM unchanged, including the RAM word whose index aliases the device address.
- R5: At most one of the three write enables is active in any cycle. When `memWrite` is low, no device register and no RAM word changes.
- R6: `readData` is combinational on `addr`. Source code 01 (device one's address) returns `dev1Out`, code 10 (device two's address) returns `dev2Out`, and code 00 (any other address) returns the addressed RAM word.
- R7: While `rstN` is low, both device registers read zero. This holds for the reset at start-up and for a reset applied later.
- R8: A device register holds its value across stores to the other device and to the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the device registers |
| addr | input | 32 | Processor byte address |
| memWrite | input | 1 | Processor store strobe |
| writeData | input | 32 | Processor store data |
| readData | output | 32 | Load data from the RAM or from a device register |
| dev1Out | output | 32 | Contents of device register one |
| dev2Out | output | 32 | Contents of device register two |

## Verification
Results arrive at two points in time. `readData` follows `addr` in the same cycle. A store becomes visible on `dev1Out`, `dev2Out`, or a later RAM load only after the one rising edge that follows it. Every stimulus is applied on a falling edge. Each expected result is queued with the number of the rising edge it is due after, and it is compared a short time after that edge. Inputs do not change until the next falling edge, so a combinational read and a registered store are both sampled exactly one rising edge after they were driven, and neither is sampled while it is changing.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  // Read source code: bit patterns are what the read mux decodes.
  typedef enum logic [1:0] {
    SEL_MEM  = 2'b00,
    SEL_DEV1 = 2'b01,
    SEL_DEV2 = 2'b10
  } rdSel_e;

  // Strobes from the decoder into the datapath.
  typedef struct packed {
    logic   wrMem;
    logic   wrDev1;
    logic   wrDev2;
    rdSel_e rdSel;
  } mmioStrobe_t;

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]    DEV1_ADDR = 32'hFFFF_FFF4,
  parameter logic [ADDR_W-1:0]    DEV2_ADDR = 32'hFFFF_FFF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memWrite,
  output mmioStrobe_t       strobe
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordAddr;
  logic              hitDev1;
  logic              hitDev2;

  assign wordAddr = addr[ADDR_W-1:2];
  assign hitDev1  = (wordAddr == DEV1_ADDR[ADDR_W-1:2]);
  assign hitDev2  = (wordAddr == DEV2_ADDR[ADDR_W-1:2]);

  always_comb begin
    strobe        = '0;
    strobe.wrDev1 = memWrite & hitDev1;
    strobe.wrDev2 = memWrite & hitDev2;
    strobe.wrMem  = memWrite & ~hitDev1 & ~hitDev2;
    if (hitDev1)      strobe.rdSel = SEL_DEV1;
    else if (hitDev2) strobe.rdSel = SEL_DEV2;
    else              strobe.rdSel = SEL_MEM;
  end

  // R5: never more than one write target per cycle
  p_one_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrMem, strobe.wrDev1, strobe.wrDev2}));

  // R4: a device read source never coincides with a RAM write
  p_dev_no_mem_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel != SEL_MEM) |-> !strobe.wrMem);

endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx   = addr[IDX_W+1:2];
  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

endmodule

// File: rtl/mmio_datapath.sv
module mmio_datapath
  import mmio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RAM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] writeData,
  input  mmioStrobe_t       strobe,
  output logic [DATA_W-1:0] readData,
  output logic [DATA_W-1:0] dev1Out,
  output logic [DATA_W-1:0] dev2Out
);

  localparam int unsigned NUM_DEV = 2;

  logic [NUM_DEV-1:0] devWe;
  logic [DATA_W-1:0]  devReg [NUM_DEV];
  logic [DATA_W-1:0]  memRdata;

  assign devWe = {strobe.wrDev2, strobe.wrDev1};

  mmio_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (RAM_DEPTH)
  ) ram (
    .clk   (clk),
    .we    (strobe.wrMem),
    .addr  (addr),
    .wdata (writeData),
    .rdata (memRdata)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         devReg[d] <= '0;
      else if (devWe[d]) devReg[d] <= writeData;
    end

    // R1 and R2: an enabled store lands in the register one edge later
    p_dev_capture_r1_r2: assert property (@(posedge clk) disable iff (!rstN)
      devWe[d] |=> (devReg[d] == $past(writeData)));

    // R8: without its own enable a register keeps its value
    p_dev_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !devWe[d] |=> $stable(devReg[d]));

    // R7: reset leaves the register cleared
    p_dev_reset_r7: assert property (@(posedge clk)
      !rstN |=> (devReg[d] == '0));
  end

  assign dev1Out = devReg[0];
  assign dev2Out = devReg[1];

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DEV1: readData = devReg[0];
      SEL_DEV2: readData = devReg[1];
      SEL_MEM:  readData = memRdata;
      default:  readData = '0;
    endcase
  end

  // R6: the source code is always one of the three legal values
  p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdSel != 2'b11);

endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
  import mmio_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       RAM_DEPTH = 64,
  parameter logic [ADDR_W-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
  parameter logic [ADDR_W-1:0] DEV2_ADDR = 32'hFFFF_FFF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memWrite,
  input  logic [DATA_W-1:0] writeData,
  output logic [DATA_W-1:0] readData,
  output logic [DATA_W-1:0] dev1Out,
  output logic [DATA_W-1:0] dev2Out
);

  mmioStrobe_t strobe;

  mmio_decode #(
    .ADDR_W    (ADDR_W),
    .DEV1_ADDR (DEV1_ADDR),
    .DEV2_ADDR (DEV2_ADDR)
  ) decode (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .memWrite (memWrite),
    .strobe   (strobe)
  );

  mmio_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RAM_DEPTH (RAM_DEPTH)
  ) datapath (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .writeData (writeData),
    .strobe    (strobe),
    .readData  (readData),
    .dev1Out   (dev1Out),
    .dev2Out   (dev2Out)
  );

  // R5: with the strobe low neither device register moves
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memWrite |=> ($stable(dev1Out) && $stable(dev2Out)));

endmodule

// File: tb/mmio_bridge_test.sv
`timescale 1ns/1ps
module mmio_bridge_test;

  localparam int  PERIOD = 20;
  localparam int  WDOG   = 5000;
  localparam int  SIG_RD = 0;
  localparam int  SIG_D1 = 1;
  localparam int  SIG_D2 = 2;
  localparam logic [31:0] DEV1 = 32'hFFFF_FFF4;
  localparam logic [31:0] DEV2 = 32'hFFFF_FFF8;

  typedef struct {
    string       req;
    int          sig;
    logic [31:0] exp;
    int          due;
  } item_t;

  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] addr = '0;
  logic        memWrite = 0;
  logic [31:0] writeData = '0;
  logic [31:0] readData, dev1Out, dev2Out;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;

  mmio_bridge uut (
    .clk(clk), .rstN(rstN), .addr(addr), .memWrite(memWrite),
    .writeData(writeData), .readData(readData),
    .dev1Out(dev1Out), .dev2Out(dev2Out)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pick(int s);
    case (s)
      SIG_D1:  return dev1Out;
      SIG_D2:  return dev2Out;
      default: return readData;
    endcase
  endfunction

  function automatic string sigName(int s);
    case (s)
      SIG_D1:  return "dev1Out";
      SIG_D2:  return "dev2Out";
      default: return "readData";
    endcase
  endfunction

  // Monitor: results are due a short time after the rising edge numbered due.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = pick(it.sig);
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: %s actual %h expected %h", it.req, sigName(it.sig), act, it.exp);
        end
      end
    end
  end

  task automatic expect_(string req, int sig, logic [31:0] val);
    item_t it;
    it.req = req; it.sig = sig; it.exp = val; it.due = cyc + 1;
    q.push_back(it);
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] d, logic we);
    @(negedge clk);
    addr = a; writeData = d; memWrite = we;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    // R7: cleared during reset
    @(negedge clk);
    expect_("R7", SIG_D1, 32'h0);
    expect_("R7", SIG_D2, 32'h0);
    @(negedge clk);
    rstN = 1;

    // R1: store 42 to device one
    drive(DEV1, 32'd42, 1);
    @(negedge clk); memWrite = 0;
    expect_("R1", SIG_D1, 32'd42);
    expect_("R8", SIG_D2, 32'h0);
    // R6: load from device one address
    expect_("R6", SIG_RD, 32'd42);

    // R2: store to device two; R8 device one unaffected
    drive(DEV2, 32'hA5A5_0001, 1);
    @(negedge clk); memWrite = 0;
    expect_("R2", SIG_D2, 32'hA5A5_0001);
    expect_("R8", SIG_D1, 32'd42);

    // R3: store to RAM word 61 (aliases device one's word index)
    drive(32'h0000_00F4, 32'h1111_2222, 1);
    @(negedge clk); memWrite = 0;
    expect_("R8", SIG_D1, 32'd42);
    expect_("R8", SIG_D2, 32'hA5A5_0001);

    // R4: device store must not touch RAM word 61
    drive(DEV1, 32'h0000_0077, 1);
    @(negedge clk); memWrite = 0;
    expect_("R1", SIG_D1, 32'h0000_0077);
    drive(32'h0000_00F4, 32'h0, 0);
    expect_("R4", SIG_RD, 32'h1111_2222);

    // R3: two RAM words and readback
    drive(32'h0000_0100, 32'h0000_CAFE, 1);
    drive(32'h0000_0104, 32'h0000_BEEF, 1);
    drive(32'h0000_0100, 32'h0, 0);
    expect_("R3", SIG_RD, 32'h0000_CAFE);
    drive(32'h0000_0104, 32'h0, 0);
    expect_("R3", SIG_RD, 32'h0000_BEEF);

    // R5: strobe low at device two address: nothing changes
    drive(DEV2, 32'h0000_DEAD, 0);
    expect_("R5", SIG_D2, 32'hA5A5_0001);
    expect_("R6", SIG_RD, 32'hA5A5_0001);
    drive(32'h0000_0100, 32'h1234_5678, 0);
    expect_("R5", SIG_RD, 32'h0000_CAFE);

    // R1: byte offset ignored
    drive(32'hFFFF_FFF7, 32'h0000_0055, 1);
    @(negedge clk); memWrite = 0;
    expect_("R1", SIG_D1, 32'h0000_0055);

    // R3: neighbours of device addresses go to RAM
    drive(32'hFFFF_FFFC, 32'h0000_0099, 1);
    drive(32'hFFFF_FFF0, 32'h0000_0088, 1);
    @(negedge clk); memWrite = 0;
    expect_("R8", SIG_D1, 32'h0000_0055);
    expect_("R8", SIG_D2, 32'hA5A5_0001);
    drive(32'h0000_00FC, 32'h0, 0);
    expect_("R3", SIG_RD, 32'h0000_0099);
    drive(32'h0000_00F0, 32'h0, 0);
    expect_("R3", SIG_RD, 32'h0000_0088);

    // R7: reset applied mid-run
    @(negedge clk);
    rstN = 0;
    expect_("R7", SIG_D1, 32'h0);
    expect_("R7", SIG_D2, 32'h0);
    @(negedge clk);
    rstN = 1;
    drive(DEV1, 32'h0, 0);
    expect_("R7", SIG_RD, 32'h0);

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R6: pending checks actual %0d expected %0d", q.size(), 0);
    end
    finish_run();
  end

  initial begin
    #(PERIOD * WDOG);
    checks++;
    fails++;
    $display("FAIL watchdog: run actual hung expected done");
    finish_run();
  end

endmodule